// File: doc/BRIEF.md
# Key-on wake-up interrupt detector

This block watches a small group of key input lines and raises a single interrupt request when a participating line is pulled low. A per-line direction register selects which lines participate. A line whose bit is 1 counts as an output and is treated as idle (high). The participating lines are synchronised and then combined by an AND into one shared level. Only a high-to-low change of that shared level makes a request. As a result, one key held down hides presses on every other participating key until it is released.

Each request sets a pending flag, which software clears with a one-cycle strobe. The pending flag drives a wake-up output while the chip is in a wait or stop low-power state. This output is purely combinational, so it still works when the core clock is gated and only the detection logic keeps running. Writing the direction register never produces a request by itself. Neither does leaving reset while a key is already held down. A shared pull-up control bit is passed straight through to the pad pull-up enable.

Top module: `keyWakeDetector`

## Requirements
- R1: After reset the direction bits are all 0 (every line participates), pending is 0 and irqPulse is 0. A key held low across reset release raises no request.
- R2: Writing dirWrData with dirWrEn high loads the direction register at that clock edge. Bit i = 1 removes keyIn[i] from detection, and bit i = 0 includes it.
- R3: When every participating line is high and one of them falls, irqPulse goes high for exactly one cycle and pending is set. Both happen at the third rising clock edge after the input change: two synchroniser edges plus one register edge.
- R4: While any participating line is low, a fall on another participating line raises no request. A request is made again only after the shared level has returned high.
- R5: Changes on a line whose direction bit is 1 raise no request.
- R6: A one-cycle clearPend strobe clears pending. If a new request edge arrives in the same cycle as the strobe, pending stays set.
- R7: wakeUp equals lowPower AND pending, combinationally, without waiting for a clock edge.
- R8: A direction-register write that changes the participating set raises no request, even when it adds a line that is already low.
- R9: pullUpEn follows pullUpCtrl.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Detection clock, kept running in stop state |
| rstN | input | 1 | Asynchronous active-low reset |
| keyIn | input | NUM_KEYS | Raw key lines, active low |
| dirWrEn | input | 1 | Direction register write strobe |
| dirWrData | input | NUM_KEYS | New direction bits (1 = excluded) |
| pullUpCtrl | input | 1 | Shared pull-up control bit |
| clearPend | input | 1 | One-cycle pending clear strobe |
| lowPower | input | 1 | High while in wait or stop state |
| pullUpEn | output | 1 | Pull-up enable for all key pads |
| irqPulse | output | 1 | One-cycle interrupt request |
| pending | output | 1 | Interrupt pending flag |
| wakeUp | output | 1 | Wake-up request out of low-power state |

## Verification
The test presses single keys on different lines to confirm the request latency and that releases are ignored. It also presses a second key while a first is held down, which separates a shared-level edge detector from a per-line one. Further tests hold excluded lines low and write the direction register while a newly included line is already low. These show that gating happens before combining and that the history reload suppresses false edges. A clear strobe placed in the exact cycle of a new edge shows which of set and clear has priority.

// File: rtl/keyWakePkg.sv
package keyWakePkg;
  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic loadHistory;  // reload edge history, suppress edge this cycle
    logic edgeArm;      // edge detection allowed this cycle
  } dpStrobes_t;
endpackage

// File: rtl/keyWakeDatapath.sv
module keyWakeDatapath
  import keyWakePkg::*;
#(
  parameter int NUM_KEYS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyIn,
  input  logic [NUM_KEYS-1:0] dirBits,
  input  dpStrobes_t          strobes,
  output logic                combinedLevel,
  output logic                fallEdge
);
  logic [NUM_KEYS-1:0] syncKey;
  logic [NUM_KEYS-1:0] gatedKey;
  logic                histLevel;

  // Per-line synchroniser, idle-high reset value.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], keyIn[k]};
    end
    assign syncKey[k] = chain[SYNC_STAGES-1];
  end

  // Excluded lines are forced to the idle level before combining.
  assign gatedKey      = syncKey | dirBits;
  assign combinedLevel = &gatedKey;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histLevel <= 1'b1;
    else       histLevel <= combinedLevel;
  end

  assign fallEdge = strobes.edgeArm & histLevel & ~combinedLevel;
endmodule

// File: rtl/keyWakeControl.sv
module keyWakeControl
  import keyWakePkg::*;
#(
  parameter int NUM_KEYS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dirWrEn,
  input  logic [NUM_KEYS-1:0] dirWrData,
  input  logic                clearPend,
  input  logic                fallEdge,
  output logic [NUM_KEYS-1:0] dirBits,
  output dpStrobes_t          strobes,
  output logic                pending,
  output logic                irqPulse
);
  localparam int SETTLE_INIT = SYNC_STAGES + 1;
  localparam int CNT_W       = $clog2(SETTLE_INIT + 1);
  localparam logic [CNT_W-1:0] SETTLE_VAL = CNT_W'(SETTLE_INIT);

  logic [CNT_W-1:0] settleCnt;
  logic             dirChangedQ;
  logic             dirChange;

  assign dirChange = dirWrEn && (dirWrData != dirBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirBits     <= '0;
      dirChangedQ <= 1'b0;
    end else begin
      if (dirWrEn) dirBits <= dirWrData;
      dirChangedQ <= dirChange;
    end
  end

  // After reset, hold history reload until the synchronisers carry real data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               settleCnt <= SETTLE_VAL;
    else if (settleCnt != 0) settleCnt <= settleCnt - 1'b1;
  end

  always_comb begin
    strobes.loadHistory = (settleCnt != 0) || dirChangedQ;
    strobes.edgeArm     = !strobes.loadHistory;
  end

  // Pending flag: set has priority over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= fallEdge;
      if (fallEdge)       pending <= 1'b1;
      else if (clearPend) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/keyWakeDetector.sv
module keyWakeDetector
  import keyWakePkg::*;
#(
  parameter int NUM_KEYS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyIn,
  input  logic                dirWrEn,
  input  logic [NUM_KEYS-1:0] dirWrData,
  input  logic                pullUpCtrl,
  input  logic                clearPend,
  input  logic                lowPower,
  output logic                pullUpEn,
  output logic                irqPulse,
  output logic                pending,
  output logic                wakeUp
);
  logic [NUM_KEYS-1:0] dirBits;
  dpStrobes_t          strobes;
  logic                combinedLevel;
  logic                fallEdge;

  keyWakeDatapath #(.NUM_KEYS(NUM_KEYS), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .dirBits(dirBits),
    .strobes(strobes), .combinedLevel(combinedLevel), .fallEdge(fallEdge)
  );

  keyWakeControl #(.NUM_KEYS(NUM_KEYS), .SYNC_STAGES(SYNC_STAGES)) i_control (
    .clk(clk), .rstN(rstN), .dirWrEn(dirWrEn), .dirWrData(dirWrData),
    .clearPend(clearPend), .fallEdge(fallEdge), .dirBits(dirBits),
    .strobes(strobes), .pending(pending), .irqPulse(irqPulse)
  );

  // Combinational so it works with the core clock gated.
  assign wakeUp   = lowPower & pending;
  assign pullUpEn = pullUpCtrl;
endmodule

// File: rtl/keyWakeChecker.sv
module keyWakeChecker #(
  parameter int NUM_KEYS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                dirWrEn,
  input logic [NUM_KEYS-1:0] dirWrData,
  input logic [NUM_KEYS-1:0] dirBits,
  input logic                clearPend,
  input logic                lowPower,
  input logic                combinedLevel,
  input logic                fallEdge,
  input logic                irqPulse,
  input logic                pending,
  input logic                wakeUp
);
  assert_req_after_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !$past(combinedLevel));

  assert_held_low_masks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(combinedLevel) && !$past(combinedLevel, 2)) |-> !irqPulse);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> (pending && irqPulse));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clearPend && !fallEdge) |=> !pending);

  assert_wake_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pending && lowPower) |-> wakeUp);

  assert_wake_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> !wakeUp);

  assert_dir_write_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrEn && (dirWrData != dirBits)) |=> !fallEdge);
endmodule

bind keyWakeDetector keyWakeChecker #(.NUM_KEYS(NUM_KEYS)) i_checker (
  .clk(clk), .rstN(rstN), .dirWrEn(dirWrEn), .dirWrData(dirWrData),
  .dirBits(dirBits), .clearPend(clearPend), .lowPower(lowPower),
  .combinedLevel(combinedLevel), .fallEdge(fallEdge), .irqPulse(irqPulse),
  .pending(pending), .wakeUp(wakeUp)
);

// File: tb/test_keyWakeDetector.sv
`timescale 1ns/1ps
module test_keyWakeDetector;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] keyIn = 4'hF;
  logic       dirWrEn = 1'b0;
  logic [3:0] dirWrData = 4'h0;
  logic       pullUpCtrl = 1'b0;
  logic       clearPend = 1'b0;
  logic       lowPower = 1'b0;
  logic       pullUpEn, irqPulse, pending, wakeUp;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  keyWakeDetector i_keyWakeDetector (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .dirWrEn(dirWrEn),
    .dirWrData(dirWrData), .pullUpCtrl(pullUpCtrl), .clearPend(clearPend),
    .lowPower(lowPower), .pullUpEn(pullUpEn), .irqPulse(irqPulse),
    .pending(pending), .wakeUp(wakeUp)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkBit(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, actual, expected);
    end
  endtask

  // Runs n cycles and reports whether any request pulse was seen.
  task automatic watchPulse(input int n, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (irqPulse) seen = 1'b1;
    end
  endtask

  task automatic writeDir(input logic [3:0] value);
    dirWrData = value;
    dirWrEn   = 1'b1;
    tick(1);
    dirWrEn   = 1'b0;
  endtask

  task automatic clearIt();
    clearPend = 1'b1;
    tick(1);
    clearPend = 1'b0;
  endtask

  task automatic testReset();
    logic seen;
    keyIn = 4'b1110;
    lowPower = 1'b1;
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    #0.1;
    checkBit("R1 pending after reset", pending, 1'b0);
    checkBit("R1 irqPulse after reset", irqPulse, 1'b0);
    checkBit("R1 wakeUp after reset", wakeUp, 1'b0);
    watchPulse(8, seen);
    checkBit("R1 no request from key held across reset", seen, 1'b0);
    checkBit("R1 pending stays clear", pending, 1'b0);
    lowPower = 1'b0;
    keyIn = 4'hF;
    tick(4);
  endtask

  task automatic testPress(input int key);
    keyIn = 4'hF;
    keyIn[key] = 1'b0;
    tick(2);
    checkBit("R3 no request before third edge", irqPulse, 1'b0);
    checkBit("R3 pending clear before third edge", pending, 1'b0);
    tick(1);
    checkBit("R3 request on third edge", irqPulse, 1'b1);
    checkBit("R3 pending set", pending, 1'b1);
    tick(1);
    checkBit("R3 request lasts one cycle", irqPulse, 1'b0);
    keyIn = 4'hF;
    tick(4);
    checkBit("R3 release leaves pending", pending, 1'b1);
    clearIt();
    checkBit("R6 clear strobe clears pending", pending, 1'b0);
  endtask

  task automatic testMask();
    logic seen;
    keyIn = 4'b1110;
    tick(4);
    clearIt();
    keyIn = 4'b1010;
    watchPulse(6, seen);
    checkBit("R4 second key masked while first held", seen, 1'b0);
    keyIn = 4'b1011;
    watchPulse(6, seen);
    checkBit("R4 releasing one of two keeps level low", seen, 1'b0);
    checkBit("R4 pending stays clear", pending, 1'b0);
    keyIn = 4'hF;
    tick(4);
    keyIn = 4'b1011;
    watchPulse(4, seen);
    checkBit("R4 request again after full release", seen, 1'b1);
    keyIn = 4'hF;
    tick(4);
    clearIt();
  endtask

  task automatic testDirection();
    logic seen;
    writeDir(4'b0001);
    keyIn = 4'b1110;
    watchPulse(6, seen);
    checkBit("R5 excluded line falling ignored", seen, 1'b0);
    keyIn = 4'b1111;
    tick(3);
    keyIn = 4'b1110;
    watchPulse(6, seen);
    checkBit("R5 excluded line toggling ignored", pending, 1'b0);
    keyIn = 4'b1100;
    watchPulse(4, seen);
    checkBit("R2 excluded low line does not mask", seen, 1'b1);
    clearIt();
    keyIn = 4'b1110;
    tick(4);
    writeDir(4'b0000);
    watchPulse(6, seen);
    checkBit("R8 including a low line raises no request", seen, 1'b0);
    checkBit("R8 pending stays clear", pending, 1'b0);
    keyIn = 4'b0110;
    watchPulse(6, seen);
    checkBit("R2 included low line now masks", seen, 1'b0);
    keyIn = 4'b1110;
    tick(4);
    writeDir(4'b0001);
    watchPulse(4, seen);
    checkBit("R8 excluding a low line raises no request", seen, 1'b0);
    keyIn = 4'b1010;
    watchPulse(4, seen);
    checkBit("R2 press after exclusion detected", seen, 1'b1);
    clearIt();
    keyIn = 4'hF;
    writeDir(4'b0000);
    tick(4);
  endtask

  task automatic testSetWins();
    keyIn = 4'b1101;
    tick(4);
    keyIn = 4'hF;
    tick(4);
    checkBit("R6 pending set before race", pending, 1'b1);
    keyIn = 4'b1101;
    tick(2);
    clearPend = 1'b1;
    tick(1);
    clearPend = 1'b0;
    checkBit("R6 set wins over simultaneous clear", pending, 1'b1);
    keyIn = 4'hF;
    tick(4);
    clearIt();
    checkBit("R6 later clear works", pending, 1'b0);
  endtask

  task automatic testWake();
    keyIn = 4'b0111;
    tick(4);
    keyIn = 4'hF;
    lowPower = 1'b0;
    #0.5;
    checkBit("R7 no wake outside low power", wakeUp, 1'b0);
    lowPower = 1'b1;
    #0.5;
    checkBit("R7 wake follows lowPower without clock", wakeUp, 1'b1);
    tick(1);
    clearIt();
    #0.5;
    checkBit("R7 wake drops with pending", wakeUp, 1'b0);
    lowPower = 1'b0;
  endtask

  task automatic testPullUp();
    pullUpCtrl = 1'b1;
    #0.5;
    checkBit("R9 pull-up enabled", pullUpEn, 1'b1);
    pullUpCtrl = 1'b0;
    #0.5;
    checkBit("R9 pull-up disabled", pullUpEn, 1'b0);
  endtask

  initial begin
    testReset();
    testPress(1);
    testPress(3);
    testMask();
    testDirection();
    testSetWins();
    testWake();
    testPullUp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule